// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Elaboration-Time Write Policy

This block is a small direct-mapped data cache. It sits between a processor that issues one word request at a time and a memory that moves whole lines. Each request address is split into three fields: a byte offset, a word select and a line index, with the remaining upper bits kept as a tag. One comparator checks the stored tag of the indexed line against the upper bits of the address. A read hit returns data without any memory traffic. A read miss replaces the indexed line with a full line fetched from memory. The requested word is then returned to the processor.

The write behaviour is fixed at elaboration by the `POLICY` parameter. There are three choices. Write-through sends every write to memory and touches the cache only on a hit. Write-back without allocation sends a write miss straight to memory and keeps a write hit in the cache alone. Write-back with allocation keeps every write in the cache and fetches the line first on a miss. Under either write-back choice, a line modified by a cache-only write is dirty. Such a line is written to memory in full before it is replaced.

Both sides use valid/ready. A processor request is taken on a cycle where `cpu_req_valid` and `cpu_req_ready` are both high. Ready stays low while the cache waits on memory, so the requester is held off until the response. Every accepted request, read or write, gets exactly one single-cycle `cpu_rsp_valid` pulse, and the response side cannot be stalled. Toward memory, the cache holds a request steady until `mem_req_ready` is seen. A read returns its line later on a single-cycle `mem_rsp_valid` pulse.

Top module: `wp_dcache`

## Requirements
- R1: With the default parameters, address bits [1:0] are ignored, bits [3:2] select the word in a line, bits [7:4] select one of 16 lines and bits [31:8] form the tag. Words sit in memory line lanes as bits [32*w+31 : 32*w].
- R2: A read hit raises `cpu_rsp_valid` with the stored word in the cycle after acceptance and issues no memory request.
- R3: A read miss issues one line read at the line-aligned address of the request. It installs the returned line and tag as clean. It responds with the requested word in the cycle after `mem_rsp_valid`.
- R4: After reset every line is invalid, so the first access to any line misses. During and just after reset, `cpu_req_ready` is high and `cpu_rsp_valid` and `mem_req_valid` are low.
- R5: Write-through: each write issues exactly one memory write with a single strobe bit, the word in its own lane. A write hit also updates the cached word. A write miss allocates nothing.
- R6: Write-back without allocation: a write miss issues one single-word memory write and leaves the cache unchanged. A write hit updates the cache only, marks the line dirty and makes no memory request.
- R7: Write-back with allocation: no write ever issues a single-word memory write. A write miss fetches the line, merges the word and marks the line dirty. A write hit updates the cache only.
- R8: Under a write-back policy, replacing a dirty line first writes the whole victim line, with all strobe bits set, at the victim's own address. Clean victims and write-through never write back.
- R9: While a memory request is pending, `cpu_req_ready` is low, and the memory request holds its address, direction and strobes until `mem_req_ready`. Each accepted processor request gets exactly one response pulse.
- R10: A read always returns the value of the most recent write to that word, across any sequence of evictions and refills.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache can take a request this cycle |
| cpu_req_we | input | 1 | 1 = write, 0 = read |
| cpu_req_addr | input | ADDR_W | Byte address |
| cpu_req_wdata | input | DATA_W | Write word |
| cpu_rsp_valid | output | 1 | Single-cycle completion pulse |
| cpu_rsp_rdata | output | DATA_W | Read word, valid with a read's response |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory takes the request this cycle |
| mem_req_we | output | 1 | 1 = write, 0 = line read |
| mem_req_addr | output | ADDR_W | Line-aligned for line transfers, word-aligned for word writes |
| mem_req_wstrb | output | WORDS | Per-word write enables |
| mem_req_wdata | output | WORDS*DATA_W | Write line, one word per lane |
| mem_rsp_valid | input | 1 | Read line returned |
| mem_rsp_rdata | input | WORDS*DATA_W | Returned line |

## Verification
The same stimulus is run against all three policies at once. Each policy is compared against its own behavioural model of line state and memory contents.

Repeated reads of one line separate a hit from a miss by memory traffic and by response latency. Reads at odd byte offsets check the address split. Writes to a line already present and to a line not yet present separate the three policies by the kind of memory write each one issues. Sweeps of dirty lines followed by conflicting reads force full-line writebacks, and the written-back data must match the newest stored values. A long pseudo-random mix over four tags on every index, with a memory that stalls and responds with varying delay, checks that reads return the last written value through any eviction order.

// File: rtl/wp_dcache_pkg.sv
package wp_dcache_pkg;
  typedef enum logic [1:0] {
    WP_THROUGH      = 2'd0,
    WP_BACK_NOALLOC = 2'd1,
    WP_BACK_ALLOC   = 2'd2
  } wpol_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WBACK,
    ST_FREQ,
    ST_FWAIT,
    ST_MEMW
  } cst_e;
endpackage

// File: rtl/wp_dcache_tags.sv
module wp_dcache_tags #(
  parameter int LINES = 16,
  parameter int TAG_W = 24,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag_in,
  output logic             hit,
  output logic             vic_valid,
  output logic             vic_dirty,
  output logic [TAG_W-1:0] vic_tag,
  input  logic             inst_en,
  input  logic             inst_dirty,
  input  logic             dirty_set,
  input  logic             dirty_clr
);
  logic [LINES-1:0] valid_q;
  logic [LINES-1:0] dirty_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (inst_en) begin
      valid_q[idx] <= 1'b1;
      dirty_q[idx] <= inst_dirty;
    end else if (dirty_set) begin
      dirty_q[idx] <= 1'b1;
    end else if (dirty_clr) begin
      dirty_q[idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (inst_en) tag_q[idx] <= tag_in;
  end

  assign vic_valid = valid_q[idx];
  assign vic_dirty = dirty_q[idx];
  assign vic_tag   = tag_q[idx];
  assign hit       = valid_q[idx] && (tag_q[idx] == tag_in);
endmodule

// File: rtl/wp_dcache_data.sv
module wp_dcache_data #(
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  localparam int IDX_W  = $clog2(LINES),
  localparam int LINE_W = WORDS * DATA_W
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  input  logic [WORDS-1:0]  wr_mask,
  input  logic [LINE_W-1:0] wr_line,
  output logic [LINE_W-1:0] rd_line
);
  for (genvar w = 0; w < WORDS; w++) begin : g_lane
    logic [DATA_W-1:0] lane_q [LINES];
    always_ff @(posedge clk) begin
      if (wr_mask[w]) lane_q[idx] <= wr_line[w*DATA_W +: DATA_W];
    end
    assign rd_line[w*DATA_W +: DATA_W] = lane_q[idx];
  end
endmodule

// File: rtl/wp_dcache_ctrl.sv
module wp_dcache_ctrl
  import wp_dcache_pkg::*;
#(
  parameter wpol_e POLICY = WP_BACK_ALLOC,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 24,
  parameter int OFF_W  = 2,
  parameter int BYTE_W = 2,
  localparam int LINE_W = WORDS * DATA_W,
  localparam int LOW_W  = OFF_W + BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [WORDS-1:0]  mem_req_wstrb,
  output logic [LINE_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_rdata,
  output logic [IDX_W-1:0]  lk_idx,
  output logic [TAG_W-1:0]  lk_tag,
  input  logic              hit,
  input  logic              vic_valid,
  input  logic              vic_dirty,
  input  logic [TAG_W-1:0]  vic_tag,
  output logic              inst_en,
  output logic              inst_dirty,
  output logic              dirty_set,
  output logic              dirty_clr,
  output logic [WORDS-1:0]  wr_mask,
  output logic [LINE_W-1:0] wr_line,
  input  logic [LINE_W-1:0] rd_line
);
  localparam bit IS_WT    = (POLICY == WP_THROUGH);
  localparam bit IS_ALLOC = (POLICY == WP_BACK_ALLOC);

  cst_e              state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              we_q;
  logic [ADDR_W-1:0] cur_addr;
  logic [OFF_W-1:0]  word;
  logic [WORDS-1:0]  word_oh;
  logic              acc, need_wb, fill_done, wr_hit, rsp_d;
  logic [LINE_W-1:0] fill_line;

  function automatic logic [DATA_W-1:0] pick(input logic [LINE_W-1:0] ln,
                                             input logic [OFF_W-1:0] w);
    pick = '0;
    for (int i = 0; i < WORDS; i++)
      if (w == OFF_W'(i)) pick = ln[i*DATA_W +: DATA_W];
  endfunction

  assign cur_addr = (state_q == ST_IDLE) ? cpu_req_addr : addr_q;
  assign lk_idx   = cur_addr[LOW_W +: IDX_W];
  assign lk_tag   = cur_addr[ADDR_W-1 -: TAG_W];
  assign word     = cur_addr[BYTE_W +: OFF_W];
  assign word_oh  = WORDS'(1) << word;
  wire unused_low = ^cur_addr[BYTE_W-1:0];

  assign cpu_req_ready = (state_q == ST_IDLE);
  assign acc       = cpu_req_ready && cpu_req_valid;
  assign need_wb   = !IS_WT && vic_valid && vic_dirty;
  assign fill_done = (state_q == ST_FWAIT) && mem_rsp_valid;
  assign wr_hit    = acc && cpu_req_we && hit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (acc) begin
        if (!cpu_req_we)   state_d = hit ? ST_IDLE : (need_wb ? ST_WBACK : ST_FREQ);
        else if (hit)      state_d = IS_WT ? ST_MEMW : ST_IDLE;
        else if (IS_ALLOC) state_d = need_wb ? ST_WBACK : ST_FREQ;
        else               state_d = ST_MEMW;
      end
      ST_WBACK: if (mem_req_ready) state_d = ST_FREQ;
      ST_FREQ:  if (mem_req_ready) state_d = ST_FWAIT;
      ST_FWAIT: if (mem_rsp_valid) state_d = ST_IDLE;
      ST_MEMW:  if (mem_req_ready) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    mem_req_valid = (state_q == ST_WBACK) || (state_q == ST_FREQ) || (state_q == ST_MEMW);
    mem_req_we    = (state_q == ST_WBACK) || (state_q == ST_MEMW);
    mem_req_wdata = {WORDS{wdata_q}};
    mem_req_wstrb = '0;
    mem_req_addr  = {lk_tag, lk_idx, {LOW_W{1'b0}}};
    if (state_q == ST_WBACK) begin
      mem_req_addr  = {vic_tag, lk_idx, {LOW_W{1'b0}}};
      mem_req_wstrb = '1;
      mem_req_wdata = rd_line;
    end else if (state_q == ST_MEMW) begin
      mem_req_addr  = {addr_q[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
      mem_req_wstrb = word_oh;
    end
  end

  always_comb begin
    fill_line = mem_rsp_rdata;
    for (int i = 0; i < WORDS; i++)
      if (we_q && word_oh[i]) fill_line[i*DATA_W +: DATA_W] = wdata_q;
  end

  always_comb begin
    wr_mask = '0;
    wr_line = fill_line;
    if (wr_hit) begin
      wr_mask = word_oh;
      wr_line = {WORDS{cpu_req_wdata}};
    end else if (fill_done) begin
      wr_mask = '1;
    end
  end

  assign inst_en    = fill_done;
  assign inst_dirty = we_q;
  assign dirty_set  = wr_hit && !IS_WT;
  assign dirty_clr  = (state_q == ST_WBACK) && mem_req_ready;

  assign rsp_d = (acc && hit && (!cpu_req_we || !IS_WT)) || fill_done ||
                 ((state_q == ST_MEMW) && mem_req_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_IDLE;
      addr_q        <= '0;
      wdata_q       <= '0;
      we_q          <= 1'b0;
      cpu_rsp_valid <= 1'b0;
      cpu_rsp_rdata <= '0;
    end else begin
      state_q       <= state_d;
      cpu_rsp_valid <= rsp_d;
      if (acc) begin
        addr_q  <= cpu_req_addr;
        wdata_q <= cpu_req_wdata;
        we_q    <= cpu_req_we;
        if (!cpu_req_we && hit) cpu_rsp_rdata <= pick(rd_line, word);
      end
      if (fill_done) cpu_rsp_rdata <= pick(mem_rsp_rdata, word);
    end
  end
endmodule

// File: rtl/wp_dcache.sv
module wp_dcache
  import wp_dcache_pkg::*;
#(
  parameter wpol_e POLICY = WP_BACK_ALLOC,
  parameter int LINES  = 16,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam int LINE_W = WORDS * DATA_W,
  localparam int BYTE_W = $clog2(DATA_W / 8),
  localparam int OFF_W  = $clog2(WORDS),
  localparam int IDX_W  = $clog2(LINES),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W - BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_we,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [DATA_W-1:0] cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [DATA_W-1:0] cpu_rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [WORDS-1:0]  mem_req_wstrb,
  output logic [LINE_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_rdata
);
  logic [IDX_W-1:0]  lk_idx;
  logic [TAG_W-1:0]  lk_tag, vic_tag;
  logic              hit, vic_valid, vic_dirty;
  logic              inst_en, inst_dirty, dirty_set, dirty_clr;
  logic [WORDS-1:0]  wr_mask;
  logic [LINE_W-1:0] wr_line, rd_line;

  wp_dcache_tags #(.LINES(LINES), .TAG_W(TAG_W)) tags_i (
    .clk(clk), .rst_n(rst_n), .idx(lk_idx), .tag_in(lk_tag), .hit(hit),
    .vic_valid(vic_valid), .vic_dirty(vic_dirty), .vic_tag(vic_tag),
    .inst_en(inst_en), .inst_dirty(inst_dirty),
    .dirty_set(dirty_set), .dirty_clr(dirty_clr)
  );

  wp_dcache_data #(.LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W)) data_i (
    .clk(clk), .idx(lk_idx), .wr_mask(wr_mask), .wr_line(wr_line), .rd_line(rd_line)
  );

  wp_dcache_ctrl #(
    .POLICY(POLICY), .WORDS(WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .IDX_W(IDX_W), .TAG_W(TAG_W), .OFF_W(OFF_W), .BYTE_W(BYTE_W)
  ) ctrl_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_we(cpu_req_we), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_rdata(cpu_rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wstrb(mem_req_wstrb), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .lk_idx(lk_idx), .lk_tag(lk_tag), .hit(hit),
    .vic_valid(vic_valid), .vic_dirty(vic_dirty), .vic_tag(vic_tag),
    .inst_en(inst_en), .inst_dirty(inst_dirty),
    .dirty_set(dirty_set), .dirty_clr(dirty_clr),
    .wr_mask(wr_mask), .wr_line(wr_line), .rd_line(rd_line)
  );
endmodule

// File: rtl/wp_dcache_chk.sv
module wp_dcache_chk
  import wp_dcache_pkg::*;
#(
  parameter wpol_e POLICY = WP_BACK_ALLOC,
  parameter int WORDS  = 4,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  localparam int LOW_W = $clog2(WORDS) + $clog2(DATA_W / 8)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req_valid,
  input logic              cpu_req_ready,
  input logic              cpu_rsp_valid,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic              mem_req_we,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic [WORDS-1:0]  mem_req_wstrb,
  input logic              mem_rsp_valid
);
  localparam bit IS_WT    = (POLICY == WP_THROUGH);
  localparam bit IS_ALLOC = (POLICY == WP_BACK_ALLOC);

  // R9
  busy_blocks_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !cpu_req_ready);

  // R9
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr) &&
      $stable(mem_req_we) && $stable(mem_req_wstrb));

  // R9
  rsp_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> $past(cpu_req_valid && cpu_req_ready) ||
      $past(mem_req_valid && mem_req_ready) || $past(mem_rsp_valid));

  // R5
  wt_single_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
    IS_WT && mem_req_valid && mem_req_we |-> $countones(mem_req_wstrb) == 1);

  // R7
  alloc_no_word_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    IS_ALLOC && mem_req_valid && mem_req_we |-> mem_req_wstrb == '1);

  // R8
  line_write_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we && mem_req_wstrb == '1 |-> mem_req_addr[LOW_W-1:0] == '0);

  // R3
  read_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_we |-> mem_req_addr[LOW_W-1:0] == '0 && mem_req_wstrb == '0);
endmodule

bind wp_dcache wp_dcache_chk #(
  .POLICY(POLICY), .WORDS(WORDS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cpu_req_valid(cpu_req_valid),
  .cpu_req_ready(cpu_req_ready), .cpu_rsp_valid(cpu_rsp_valid),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
  .mem_req_wstrb(mem_req_wstrb), .mem_rsp_valid(mem_rsp_valid)
);

// File: tb/wp_dcache_tb_h.sv
module wp_dcache_tb_h
  import wp_dcache_pkg::*;
#(
  parameter wpol_e POLICY = WP_BACK_ALLOC
) (
  input  logic clk,
  input  logic rst_n,
  output logic done,
  output int   n_chk,
  output int   n_err
);
  logic         req_valid = 1'b0, req_we = 1'b0;
  logic [31:0]  req_addr = '0, req_wdata = '0;
  logic         ready, rsp_valid;
  logic [31:0]  rsp_rdata;
  logic         mem_req_valid, mem_req_we;
  logic         mem_req_ready = 1'b0;
  logic [31:0]  mem_req_addr;
  logic [3:0]   mem_req_wstrb;
  logic [127:0] mem_req_wdata;
  logic         mem_rsp_valid = 1'b0;
  logic [127:0] mem_rsp_rdata = '0;

  wp_dcache #(.POLICY(POLICY)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(req_valid), .cpu_req_ready(ready), .cpu_req_we(req_we),
    .cpu_req_addr(req_addr), .cpu_req_wdata(req_wdata),
    .cpu_rsp_valid(rsp_valid), .cpu_rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wstrb(mem_req_wstrb), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  logic [31:0] mem_m [int];
  logic [31:0] gold  [int];
  bit          vm [16];
  int          tm [16];
  bit          dm [16];
  int got_rd = 0, got_lw = 0, got_ww = 0, pend = 0, cyc = 0, n_req = 0, n_rsp = 0;
  logic [31:0] pend_addr = '0;

  initial begin n_chk = 0; n_err = 0; done = 1'b0; end

  function automatic logic [31:0] init_w(int wi);
    return (32'(wi) * 32'h9E3779B1) ^ 32'h5A5A0000;
  endfunction
  function automatic logic [31:0] mrd(int wi);
    return mem_m.exists(wi) ? mem_m[wi] : init_w(wi);
  endfunction
  function automatic logic [31:0] grd(int wi);
    return gold.exists(wi) ? gold[wi] : init_w(wi);
  endfunction

  task automatic chk(input bit ok, input string r, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s policy %0d %s: actual %h expected %h", r, POLICY, what, act, exp);
    end
  endtask

  // memory model and per-clock monitor
  always @(negedge clk) begin
    if (rst_n) begin
      cyc++;
      if (rsp_valid) n_rsp++;
      mem_rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin
          mem_rsp_valid = 1'b1;
          for (int w = 0; w < 4; w++)
            mem_rsp_rdata[w*32 +: 32] = mrd(int'(pend_addr[31:2]) + w);
        end
      end
      mem_req_ready = ((cyc % 4) != 2);
      if (mem_req_valid && mem_req_ready) begin
        if (mem_req_we) begin
          if (mem_req_wstrb == 4'b1111) begin
            got_lw++;
            for (int w = 0; w < 4; w++) begin
              // R8 written-back line carries the newest data
              chk(mem_req_wdata[w*32 +: 32] == grd(int'(mem_req_addr[31:2]) + w), "R8",
                  "writeback word", mem_req_wdata[w*32 +: 32], grd(int'(mem_req_addr[31:2]) + w));
              mem_m[int'(mem_req_addr[31:2]) + w] = mem_req_wdata[w*32 +: 32];
            end
          end else begin
            got_ww++;
            // R5 single word write lands in its own lane
            chk(mem_req_wstrb == (4'b1 << mem_req_addr[3:2]), "R5", "word strobe",
                32'(mem_req_wstrb), 32'(4'b1 << mem_req_addr[3:2]));
            chk(mem_req_wdata[mem_req_addr[3:2]*32 +: 32] == grd(int'(mem_req_addr[31:2])), "R5",
                "word data", mem_req_wdata[mem_req_addr[3:2]*32 +: 32], grd(int'(mem_req_addr[31:2])));
            mem_m[int'(mem_req_addr[31:2])] = mem_req_wdata[mem_req_addr[3:2]*32 +: 32];
          end
        end else begin
          got_rd++;
          pend = 1 + (cyc % 3);
          pend_addr = mem_req_addr;
        end
      end
    end
  end

  task automatic req(input bit we, input logic [31:0] a, input logic [31:0] d, input string r);
    int idx, tg, wi, n, e_rd, e_lw, e_ww;
    bit hit;
    idx = int'(a[7:4]); tg = int'(a[31:8]); wi = int'(a[31:2]);
    n = 0; e_rd = 0; e_lw = 0; e_ww = 0;
    hit = vm[idx] && (tm[idx] == tg);
    if (!we) begin
      if (!hit) begin
        e_rd = 1;
        if (POLICY != WP_THROUGH && vm[idx] && dm[idx]) e_lw = 1;
        vm[idx] = 1; tm[idx] = tg; dm[idx] = 0;
      end
    end else begin
      case (POLICY)
        WP_THROUGH: e_ww = 1;
        WP_BACK_NOALLOC: if (hit) dm[idx] = 1; else e_ww = 1;
        default: begin
          if (!hit) begin
            e_rd = 1;
            if (vm[idx] && dm[idx]) e_lw = 1;
            vm[idx] = 1; tm[idx] = tg;
          end
          dm[idx] = 1;
        end
      endcase
    end
    @(negedge clk);
    while (!ready) @(negedge clk);
    got_rd = 0; got_lw = 0; got_ww = 0;
    if (we) gold[wi] = d;
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    n_req++;
    if (e_rd + e_lw + e_ww > 0)
      chk(!ready, "R9", "ready low while busy", 32'(ready), 32'd0);
    while (!rsp_valid && n < 2000) begin @(negedge clk); n++; end
    chk(rsp_valid, "R9", "response seen", 32'(rsp_valid), 32'd1);
    if (!we) chk(rsp_rdata == grd(wi), r, "read data", rsp_rdata, grd(wi));
    if (!we && hit) chk(n == 0 && got_rd == 0, "R2", "hit latency", 32'(n), 32'd0);
    chk(got_rd == e_rd, we ? "R7" : "R3", "line reads", 32'(got_rd), 32'(e_rd));
    chk(got_lw == e_lw, "R8", "line writebacks", 32'(got_lw), 32'(e_lw));
    chk(got_ww == e_ww, POLICY == WP_THROUGH ? "R5" : "R6", "word writes",
        32'(got_ww), 32'(e_ww));
  endtask

  initial begin
    logic [31:0] x;
    for (int i = 0; i < 16; i++) begin vm[i] = 0; dm[i] = 0; tm[i] = 0; end
    wait (rst_n === 1'b0);
    @(negedge clk);
    // R4 reset values
    chk(ready === 1'b1, "R4", "ready in reset", 32'(ready), 32'd1);
    chk(rsp_valid === 1'b0 && mem_req_valid === 1'b0, "R4", "idle outputs in reset",
        32'({rsp_valid, mem_req_valid}), 32'd0);
    wait (rst_n === 1'b1);
    @(negedge clk);
    chk(ready === 1'b1 && mem_req_valid === 1'b0, "R4", "idle after reset",
        32'({ready, mem_req_valid}), 32'd2);
    req(0, 32'h0000_0104, 0, "R4");          // cold miss
    req(0, 32'h0000_0104, 0, "R2");          // hit
    req(0, 32'h0000_010B, 0, "R1");          // offset bits ignored, word 2
    req(1, 32'h0000_0108, 32'hDEAD_0001, "R5");
    req(0, 32'h0000_010A, 0, "R1");
    req(1, 32'h0000_1200, 32'hBEEF_0002, "R6"); // write miss
    req(0, 32'h0000_1200, 0, "R7");
    req(0, 32'h0000_2108, 0, "R8");          // conflict on index 0
    req(0, 32'h0000_0108, 0, "R10");
    req(1, 32'h0000_3404, 32'hCAFE_0003, "R7");
    req(1, 32'h0000_3404, 32'hCAFE_0004, "R6");
    req(0, 32'h0000_3404, 0, "R10");
    for (int i = 0; i < 16; i++) req(1, 32'h5004 | (i << 4), 32'hA000_0000 | i, "R8");
    for (int i = 0; i < 16; i++) req(0, 32'h6000 | (i << 4), 0, "R8");
    for (int i = 0; i < 16; i++) req(0, 32'h5004 | (i << 4), 0, "R10");
    x = 32'h1234_5679;
    for (int k = 0; k < 200; k++) begin
      x ^= x << 13; x ^= x >> 17; x ^= x << 5;
      req(x[20], {22'h0, x[9:8], x[7:0]}, x ^ 32'hC0FF_EE00, "R10");
    end
    @(negedge clk);
    chk(n_rsp == n_req, "R9", "one response per request", 32'(n_rsp), 32'(n_req));
    done = 1'b1;
  end
endmodule

// File: tb/wp_dcache_tb_top.sv
`timescale 1ns/1ps
module wp_dcache_tb_top;
  import wp_dcache_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] done;
  int   nchk [3];
  int   nerr [3];
  bit   wd = 1'b0;

  always #2.5 clk = ~clk;

  for (genvar p = 0; p < 3; p++) begin : g_p
    wp_dcache_tb_h #(.POLICY(wpol_e'(p))) h_i (
      .clk(clk), .rst_n(rst_n), .done(done[p]), .n_chk(nchk[p]), .n_err(nerr[p])
    );
  end

  initial begin
    repeat (150000) @(posedge clk);
    wd = 1'b1;
  end

  initial begin
    int c, e;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    wait ((done == 3'b111) || wd);
    c = 0; e = 0;
    for (int p = 0; p < 3; p++) begin c += nchk[p]; e += nerr[p]; end
    if (wd) begin
      c++; e++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("CHECKS %0d ERRORS %0d", c, e);
    $finish;
  end
endmodule